// File: doc/BRIEF.md
# Log-Domain Add, Subtract and Halve Unit

This unit takes two signed fixed-point base-2 logarithms and forms the logarithm of their product, their quotient, or the square root of the first. Multiplying values means adding their logs. Dividing means subtracting them. Taking a square root means halving a log. All three operations share one carry-propagate adder.

Subtraction needs no separate negation stage and no carry-in port. The adder is widened by one bit at the bottom. The first operand gets a constant 1 in that extra position. The second operand is inverted and gets a 1 there when subtracting, and is passed through with a 0 when adding. The carry that this extra column produces becomes the "+1" of two's complement negation. The extra sum bit is then dropped.

For the square root, the second operand is replaced by zero, which is the log of one. The sum is then shifted right arithmetically by one bit. The result is registered, so each answer appears one clock after its inputs. Results wrap modulo 2^W: there is no saturation and no error correction.

Top module: `log_addsub_halve`

## Requirements
- R1: While `rst_ni` is low, `log_q_o` is zero. Asserting `rst_ni` low clears the output without waiting for a clock edge.
- R2: Command code 2'b00 is multiply. One rising edge after the inputs are applied, `log_q_o` equals `log_a_i + log_b_i` modulo 2^W.
- R3: Command code 2'b01 is divide. One rising edge later, `log_q_o` equals `log_a_i - log_b_i` modulo 2^W.
- R4: Command code 2'b10 is square root. One rising edge later, `log_q_o` equals `log_a_i` shifted right by one bit with the sign bit copied into the top bit. `log_b_i` has no effect on the result.
- R5: Command code 2'b11 gives the same result as code 2'b00.
- R6: Sums and differences that leave the signed W-bit range wrap around and are not clamped. For example, 0x7FFF + 0x0001 gives 0x8000, and 0x8000 - 0x0001 gives 0x7FFF.
- R7: A new command can be issued on every cycle. Each rising edge loads the result of the inputs present just before that edge.
- R8: After `rst_ni` rises, the first two rising edges leave `log_q_o` at zero. The third rising edge loads a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| cmd_i | input | 2 | Operation code: 00 multiply, 01 divide, 10 square root, 11 multiply |
| log_a_i | input | W | First signed log operand |
| log_b_i | input | W | Second signed log operand |
| log_q_o | output | W | Registered signed log result |

## Verification
Every result is due on the first rising edge after its inputs are applied. The bench drives inputs on the falling edge and reads `log_q_o` one time unit after the next rising edge. The vector table is fed one entry per cycle, so every read also shows that the previous cycle's inputs no longer affect the output. After reset is released, the bench reads the output after each of the first three edges: the output must be zero after the first two and must carry a result after the third. A reset asserted in the middle of the run is checked before any further clock edge.

// File: rtl/log_addsub_pkg.sv
package log_addsub_pkg;

  typedef enum logic [1:0] {
    CMD_MUL  = 2'b00,
    CMD_DIV  = 2'b01,
    CMD_ROOT = 2'b10,
    CMD_ALT  = 2'b11
  } log_cmd_e;

  typedef struct packed {
    logic zero_b;
    logic subtract;
    logic halve;
  } log_ctrl_t;

endpackage

// File: rtl/log_rst_sync.sv
module log_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/log_cmd_decode.sv
module log_cmd_decode
  import log_addsub_pkg::*;
(
  input  logic [1:0] cmd_i,
  output log_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{zero_b: 1'b0, subtract: 1'b0, halve: 1'b0};
    unique case (log_cmd_e'(cmd_i))
      CMD_DIV:  ctrl_o.subtract = 1'b1;
      CMD_ROOT: begin
        ctrl_o.zero_b = 1'b1;
        ctrl_o.halve  = 1'b1;
      end
      CMD_MUL, CMD_ALT: ctrl_o = '{zero_b: 1'b0, subtract: 1'b0, halve: 1'b0};
      default:  ctrl_o = '{zero_b: 1'b0, subtract: 1'b0, halve: 1'b0};
    endcase
  end
endmodule

// File: rtl/log_pad_adder.sv
module log_pad_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         zero_b_i,
  input  logic         subtract_i,
  output logic [W-1:0] sum_o
);
  localparam int PW = W + 1;

  logic [W-1:0]  b_sel;
  logic [W-1:0]  b_oper;
  logic [PW-1:0] a_pad;
  logic [PW-1:0] b_pad;
  logic [PW-1:0] sum_pad;

  always_comb begin
    b_sel   = zero_b_i ? '0 : b_i;
    b_oper  = subtract_i ? ~b_sel : b_sel;
    // Extra bottom column: 1+1 carries into bit 1 when subtracting, 1+0 does not.
    a_pad   = {a_i, 1'b1};
    b_pad   = {b_oper, subtract_i};
    sum_pad = a_pad + b_pad;
    sum_o   = sum_pad[PW-1:1];
  end
endmodule

// File: rtl/log_halve_stage.sv
module log_halve_stage #(
  parameter int W     = 16,
  parameter bit ARITH = 1'b1
) (
  input  logic [W-1:0] val_i,
  input  logic         halve_i,
  output logic [W-1:0] val_o
);
  logic fill;

  generate
    if (ARITH) begin : g_arith
      assign fill = val_i[W-1];
    end else begin : g_logic
      assign fill = 1'b0;
    end
  endgenerate

  always_comb begin
    val_o = halve_i ? {fill, val_i[W-1:1]} : val_i;
  end
endmodule

// File: rtl/log_addsub_halve.sv
module log_addsub_halve
  import log_addsub_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   cmd_i,
  input  logic [W-1:0] log_a_i,
  input  logic [W-1:0] log_b_i,
  output logic [W-1:0] log_q_o
);
  logic         rst_ok;
  log_ctrl_t    ctrl;
  logic [W-1:0] sum;
  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  log_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_ok)
  );

  log_cmd_decode i_decode (
    .cmd_i (cmd_i),
    .ctrl_o(ctrl)
  );

  log_pad_adder #(.W(W)) i_adder (
    .a_i       (log_a_i),
    .b_i       (log_b_i),
    .zero_b_i  (ctrl.zero_b),
    .subtract_i(ctrl.subtract),
    .sum_o     (sum)
  );

  log_halve_stage #(.W(W), .ARITH(1'b1)) i_halve (
    .val_i  (sum),
    .halve_i(ctrl.halve),
    .val_o  (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ok) begin
    if (!rst_ok) q_q <= '0;
    else         q_q <= q_d;
  end

  assign log_q_o = q_q;

  assert_mul_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cmd_i) == 2'b00) |->
      log_q_o == W'($past(log_a_i) + $past(log_b_i)));

  assert_div_diff_R3: assert property (@(posedge clk_i) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cmd_i) == 2'b01) |->
      log_q_o == W'($past(log_a_i) - $past(log_b_i)));

  assert_root_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cmd_i) == 2'b10) |->
      log_q_o == {$past(log_a_i[W-1]), $past(log_a_i[W-1:1])});

  assert_alt_is_mul_R5: assert property (@(posedge clk_i) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cmd_i) == 2'b11) |->
      log_q_o == W'($past(log_a_i) + $past(log_b_i)));
endmodule

// File: tb/test_log_addsub_halve.sv
module test_log_addsub_halve;
  localparam int W      = 16;
  localparam int PERIOD = 10;
  localparam int NV     = 14;

  localparam logic [1:0]   V_CMD [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10,
                                           2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11,
                                           2'b01, 2'b00};
  localparam logic [W-1:0] V_A   [NV] = '{16'h0340, 16'h7FFF, 16'h0500, 16'h8000,
                                           16'h0003, 16'hFFFF, 16'hF001, 16'h1234,
                                           16'hFF00, 16'h0100, 16'h7FFE, 16'h7FFF,
                                           16'h0000, 16'h0000};
  localparam logic [W-1:0] V_B   [NV] = '{16'h0120, 16'h0001, 16'h0180, 16'h0001,
                                           16'hABCD, 16'h1111, 16'h0000, 16'h4321,
                                           16'hFF00, 16'h0300, 16'hFFFF, 16'h0002,
                                           16'h8000, 16'h0000};
  localparam string        V_TAG [NV] = '{"R2", "R6", "R3", "R6", "R4", "R4", "R4", "R5",
                                           "R2", "R3", "R4", "R5", "R6", "R7"};

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [1:0]   cmd_i;
  logic [W-1:0] log_a_i, log_b_i;
  logic [W-1:0] log_q_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  log_addsub_halve #(.W(W)) i_log_addsub_halve (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .log_a_i(log_a_i),
    .log_b_i(log_b_i),
    .log_q_o(log_q_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  function automatic logic [W-1:0] expect_q(logic [1:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    if (c == 2'b01)      r = a - b;
    else if (c == 2'b10) r = {a[W-1], a[W-1:1]};
    else                 r = a + b;
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: log_q_o=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    rst_ni  = 1'b0;
    cmd_i   = 2'b00;
    log_a_i = 16'h1111;
    log_b_i = 16'h2222;
    repeat (3) after_edge();
    check("R1 held reset", log_q_o, '0);

    // Release on a falling edge; two edges stay at zero, the third loads.
    @(negedge clk_i);
    rst_ni = 1'b1;
    after_edge();
    check("R8 edge1", log_q_o, '0);
    after_edge();
    check("R8 edge2", log_q_o, '0);
    after_edge();
    check("R8 edge3", log_q_o, 16'h3333);

    // One vector per cycle, back to back.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      cmd_i   = V_CMD[i];
      log_a_i = V_A[i];
      log_b_i = V_B[i];
      after_edge();
      check(V_TAG[i], log_q_o, expect_q(V_CMD[i], V_A[i], V_B[i]));
    end

    // Square root ignores the second operand: same a, two different b.
    @(negedge clk_i);
    cmd_i = 2'b10; log_a_i = 16'h0A01; log_b_i = 16'h0000;
    after_edge();
    check("R4 b=0000", log_q_o, 16'h0500);
    @(negedge clk_i);
    log_b_i = 16'hFFFF;
    after_edge();
    check("R4 b=FFFF", log_q_o, 16'h0500);

    // Code 11 against code 00 on the same operands.
    @(negedge clk_i);
    cmd_i = 2'b11; log_a_i = 16'hC000; log_b_i = 16'hC000;
    after_edge();
    check("R5 wrap", log_q_o, 16'h8000);

    // Reset in mid-run clears the output before the next edge.
    @(negedge clk_i);
    cmd_i = 2'b00; log_a_i = 16'h0101; log_b_i = 16'h0101;
    after_edge();
    check("R7 pre-reset", log_q_o, 16'h0202);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", log_q_o, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: log_q_o=%h expected=run complete", log_q_o);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule